// File: doc/BRIEF.md
# LFSR Memory Pattern Self-Test Engine

This block is a built-in self-test engine that exercises a contiguous region of external memory with 64-bit pseudo-random words. It acts as the only master on a simple request/grant memory port and walks the region three times. The fill pass stores a sequence of generator outputs. The check pass reads each word back, compares it and, on a match, overwrites the word with its bitwise inverse. The verify pass reads each word again and expects that inverse. The expected data is never stored. A single fixed seed is reloaded into the generator at the start of each pass, so every pass replays the same sequence.

A one-cycle start request launches a run. The engine finishes with a one-cycle done pulse and a held verdict: either pass, or fail with the byte address of the first word that miscompared. The region base and its length in words are parameters. The base is forced to a multiple of eight bytes.

Top module: `lfsr_mem_bist`

## Requirements
- R1: The generator is loaded with the seed 10041518462085691392 at the start of each pass. It steps once before each word is used, so word 0 holds the seed's successor. One step computes the new bit as the XOR of state bits 0, 1, 3 and 4, shifts the state right by one, and places the new bit at bit 63.
- R2: Every access uses an address of the form (BASE_ADDR with bits 2:0 cleared) + 8*i, where 0 <= i < NUM_WORDS. Within a pass, i rises from 0 in steps of one.
- R3: The fill pass writes pattern i to word i for every word of the region.
- R4: The check pass reads word i and compares it with pattern i. On a match it writes the inverse of pattern i to the same address before it moves to word i+1.
- R5: The verify pass reads word i and compares it with the inverse of pattern i.
- R6: On the first mismatch the run ends at once. No further access is issued, `fail` is set, and `fail_addr` holds the address of the word that miscompared.
- R7: A run with no mismatch ends with `pass`=1, `fail`=0 and `fail_addr`=0. `pass` and `fail` are never high together.
- R8: Only one access is outstanding. After a read is granted, `mem_req` stays low until `mem_rvalid` has been seen.
- R9: `start` has no effect while `busy` is high.
- R10: After reset `busy`, `done`, `pass`, `fail` and `mem_req` are 0. `done` is high for exactly one cycle per run. `pass`, `fail` and `fail_addr` hold their values until the next accepted start, which clears them.
- R11: While `mem_req` is high and `mem_gnt` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged in the next cycle.
- R12: `busy` is low in the cycle where `done` is high. A `start` seen in that cycle begins a new run on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| pass | output | 1 | Held: last run found no mismatch |
| fail | output | 1 | Held: last run stopped on a mismatch |
| fail_addr | output | ADDR_W | Held: address of the first mismatch, 0 on pass |
| mem_req | output | 1 | Access request, held until granted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 64 | Write data |
| mem_gnt | input | 1 | Request accepted; completes a write |
| mem_rdata | input | 64 | Read data, valid with mem_rvalid |
| mem_rvalid | input | 1 | Read data returned |

## Verification
Completion of a run and acceptance of a new start can fall on the same cycle, because the done pulse is raised together with the return to idle. The bench provokes this by holding `start` high through a failing run. It expects a fresh run to begin one edge after `done`, with the previous verdict cleared, and the second run must reach the same verdict. A second overlap also matters: a start request can arrive in the cycle the engine leaves a pass. This is covered by sending repeated start pulses during a run. The run length and the done count must then match an undisturbed run.

// File: rtl/bist_pkg.sv
// Shared types and the pattern step function for the memory self-test engine.
// Assumes 64-bit test words; the feedback taps are fixed for that width.
package bist_pkg;
    localparam int WORD_W = 64;
    localparam logic [WORD_W-1:0] DEF_SEED = 64'd10041518462085691392;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_WAIT,
        ST_CWRITE
    } st_t;

    typedef enum logic [1:0] {
        PH_FILL,
        PH_CHECK,
        PH_VERIFY
    } ph_t;

    // One generator step: feedback bit into the top, state moves right.
    function automatic logic [WORD_W-1:0] lfsr_next(input logic [WORD_W-1:0] s);
        return {s[0] ^ s[1] ^ s[3] ^ s[4], s[WORD_W-1:1]};
    endfunction
endpackage

// File: rtl/bist_lfsr.sv
// Pattern source. A reload puts the seed's successor in the state, so the
// word-0 pattern is ready at once; an advance moves to the next word's pattern.
// Assumes reload and advance are never high together.
module bist_lfsr
    import bist_pkg::*;
#(
    parameter logic [WORD_W-1:0] SEED = DEF_SEED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload,
    input  logic              advance,
    output logic [WORD_W-1:0] pattern
);
    // Hold, reload or step the generator state.
    always_ff @(posedge clk) begin
        if (!rst_n)       pattern <= lfsr_next(SEED);
        else if (reload)  pattern <= lfsr_next(SEED);
        else if (advance) pattern <= lfsr_next(pattern);
    end
endmodule

// File: rtl/bist_addr.sv
// Word index counter and byte address former for the test region.
// Assumes NUM_WORDS >= 2; the base is aligned to 8 bytes here.
module bist_addr #(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h8000_0000,
    parameter int                NUM_WORDS = 1280
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam int                IDX_W   = $clog2(NUM_WORDS);
    localparam logic [ADDR_W-1:0] BASE_AL = BASE_ADDR & ~ADDR_W'(7);
    localparam logic [IDX_W-1:0]  IDX_TOP = IDX_W'(NUM_WORDS - 1);

    logic [IDX_W-1:0] idx;

    // Count words within a pass.
    always_ff @(posedge clk) begin
        if (!rst_n)     idx <= '0;
        else if (clear) idx <= '0;
        else if (step)  idx <= idx + 1'b1;
    end

    // Byte address of the current word and end-of-region flag.
    always_comb begin
        addr = BASE_AL + (ADDR_W'(idx) << 3);
        last = (idx == IDX_TOP);
    end

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear) |-> (idx != IDX_TOP)); // R2
endmodule

// File: rtl/bist_ctrl.sv
// Pass sequencer: issues one access at a time on the memory port, compares
// returned data with the replayed pattern, and records the verdict.
// Assumes the pattern and address inputs track the word being processed.
module bist_ctrl
    import bist_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] pattern,
    input  logic [ADDR_W-1:0] addr,
    input  logic              last,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              lfsr_reload,
    output logic              lfsr_adv,
    output logic              idx_clr,
    output logic              idx_step,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr
);
    st_t state;
    ph_t phase;

    logic              accept;
    logic              wr_ok;
    logic              rd_back;
    logic              mismatch;
    logic [WORD_W-1:0] want;

    // Decode the events of the current cycle and the counter controls.
    always_comb begin
        accept      = (state == ST_IDLE) && start;
        wr_ok       = ((state == ST_WRITE) || (state == ST_CWRITE)) && mem_gnt;
        rd_back     = (state == ST_WAIT) && mem_rvalid;
        want        = (phase == PH_CHECK) ? pattern : ~pattern;
        mismatch    = rd_back && (mem_rdata != want);
        lfsr_reload = accept || (wr_ok && last);
        idx_clr     = lfsr_reload;
        lfsr_adv    = (wr_ok && !last) ||
                      (rd_back && !mismatch && (phase == PH_VERIFY) && !last);
        idx_step    = lfsr_adv;
    end

    // Drive the memory port from the state.
    always_comb begin
        mem_req   = (state == ST_WRITE) || (state == ST_READ) || (state == ST_CWRITE);
        mem_we    = (state == ST_WRITE) || (state == ST_CWRITE);
        mem_wdata = (state == ST_WRITE) ? pattern : ~pattern;
        busy      = (state != ST_IDLE);
    end

    // Pass sequencing and verdict registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            phase     <= PH_FILL;
            done      <= 1'b0;
            pass      <= 1'b0;
            fail      <= 1'b0;
            fail_addr <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state     <= ST_WRITE;
                        phase     <= PH_FILL;
                        pass      <= 1'b0;
                        fail      <= 1'b0;
                        fail_addr <= '0;
                    end
                end
                ST_WRITE: begin
                    if (mem_gnt && last) begin
                        phase <= PH_CHECK;
                        state <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (mem_gnt) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mismatch) begin
                        fail      <= 1'b1;
                        fail_addr <= addr;
                        done      <= 1'b1;
                        state     <= ST_IDLE;
                    end else if (rd_back) begin
                        if (phase == PH_CHECK) begin
                            state <= ST_CWRITE;
                        end else if (last) begin
                            pass  <= 1'b1;
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_READ;
                        end
                    end
                end
                ST_CWRITE: begin
                    if (mem_gnt) begin
                        state <= ST_READ;
                        if (last) phase <= PH_VERIFY;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_NO_REQ_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> !mem_req); // R8
    AST_CWRITE_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CWRITE) |-> (phase == PH_CHECK)); // R4
    AST_FAIL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> (!busy && !mem_req)); // R6
endmodule

// File: rtl/lfsr_mem_bist.sv
// Top of the memory pattern self-test engine: pattern source, address
// counter and pass sequencer. Assumes a memory that grants each request
// and returns read data some cycles after the read grant.
module lfsr_mem_bist
    import bist_pkg::*;
#(
    parameter int                     ADDR_W    = 32,
    parameter logic [ADDR_W-1:0]      BASE_ADDR = 32'h8000_0000,
    parameter int                     NUM_WORDS = 1280,
    parameter logic [WORD_W-1:0]      SEED      = DEF_SEED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_rvalid
);
    logic              lfsr_reload;
    logic              lfsr_adv;
    logic              idx_clr;
    logic              idx_step;
    logic              last;
    logic [WORD_W-1:0] pattern;

    bist_lfsr #(.SEED(SEED)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (lfsr_reload),
        .advance (lfsr_adv),
        .pattern (pattern)
    );

    bist_addr #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .NUM_WORDS (NUM_WORDS)
    ) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (idx_clr),
        .step  (idx_step),
        .addr  (mem_addr),
        .last  (last)
    );

    bist_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .pattern     (pattern),
        .addr        (mem_addr),
        .last        (last),
        .mem_gnt     (mem_gnt),
        .mem_rvalid  (mem_rvalid),
        .mem_rdata   (mem_rdata),
        .lfsr_reload (lfsr_reload),
        .lfsr_adv    (lfsr_adv),
        .idx_clr     (idx_clr),
        .idx_step    (idx_step),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_wdata   (mem_wdata),
        .busy        (busy),
        .done        (done),
        .pass        (pass),
        .fail        (fail),
        .fail_addr   (fail_addr)
    );

    AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == 3'b000)); // R2
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_gnt) |=> !mem_req); // R8
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) &&
                                   $stable(mem_addr) && $stable(mem_wdata))); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(pass) && $stable(fail) && $stable(fail_addr))); // R10
    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R12
    AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail)); // R7
endmodule

// File: tb/sim_lfsr_mem_bist.sv
module sim_lfsr_mem_bist;
    localparam int          NW    = 1280;
    localparam logic [31:0] BASE  = 32'h0000_1005;
    localparam logic [31:0] ALIGN = 32'h0000_1000;
    localparam logic [63:0] SEEDV = 64'd10041518462085691392;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, done, pass, fail;
    logic [31:0] fail_addr;
    logic mem_req, mem_we, mem_gnt, mem_rvalid;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata, mem_rdata;

    int errors = 0;
    int checks = 0;
    int range_errs = 0;
    int done_cnt = 0;

    logic [63:0] exp_pat [NW];
    logic [63:0] ram [NW];
    logic        clr_ram = 1'b0;
    logic        flt_en = 1'b0;
    int          flt_idx = 0;
    logic [63:0] flt_mask = '0;
    logic [63:0] flt_val = '0;
    logic        waited = 1'b0;
    logic        rd_pend = 1'b0;
    logic [1:0]  rd_dly = '0;
    logic [63:0] rd_data = '0;
    logic [31:0] off;
    int          widx;

    always #2 clk = ~clk;

    lfsr_mem_bist #(.ADDR_W(32), .BASE_ADDR(BASE), .NUM_WORDS(NW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .pass(pass), .fail(fail), .fail_addr(fail_addr), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
    );

    // Behavioural memory: accesses to odd-word addresses wait one cycle for grant.
    assign off        = mem_addr - ALIGN;
    assign widx       = int'(off >> 3);
    assign mem_gnt    = mem_req && (!mem_addr[3] || waited);
    assign mem_rvalid = rd_pend && (rd_dly == 2'd0);
    assign mem_rdata  = rd_data;

    always @(posedge clk) begin
        waited <= mem_req && !mem_gnt;
        if (mem_rvalid) rd_pend <= 1'b0;
        else if (rd_pend) rd_dly <= rd_dly - 2'd1;
        if (clr_ram) begin
            for (int i = 0; i < NW; i++) ram[i] <= 64'hA5A5_0F0F_3C3C_7E7E;
        end else if (mem_req && mem_gnt) begin
            if (off[2:0] != 3'd0 || mem_addr < ALIGN || widx >= NW) begin
                range_errs <= range_errs + 1;
            end else if (mem_we) begin
                if (flt_en && widx == flt_idx)
                    ram[widx] <= (mem_wdata & ~flt_mask) | (flt_val & flt_mask);
                else
                    ram[widx] <= mem_wdata;
            end else begin
                if (rd_pend) range_errs <= range_errs + 1;
                rd_pend <= 1'b1;
                rd_dly  <= {1'b0, mem_addr[4]};
                rd_data <= ram[widx];
            end
        end
        if (done) done_cnt <= done_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic clear_mem();
        @(negedge clk); clr_ram = 1'b1;
        @(negedge clk); clr_ram = 1'b0;
    endtask

    // Start one run; optionally poke start while busy; wait for done.
    task automatic run_once(input bit poke, output int cyc);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0; cyc = 1;
        while (!done && cyc < 40000) begin
            start = poke && (cyc % 97 == 0);
            @(negedge clk); cyc++;
        end
        start = 1'b0;
        if (!done) chk(1'b0, "watchdog", 64'(cyc), 64'd40000);
    endtask

    task automatic after_done();
        @(negedge clk);
        chk(!done && !busy, "R10 done one cycle", {62'd0, done, busy}, 64'd0);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !pass && !fail && !mem_req, "R10 reset state",
            {59'd0, busy, done, pass, fail, mem_req}, 64'd0);
    endtask

    task automatic t_clean(output int cyc);
        int bad;
        flt_en = 1'b0;
        clear_mem();
        run_once(1'b0, cyc);
        chk(pass && !fail, "R7 verdict pass", {62'd0, pass, fail}, 64'd2);
        chk(fail_addr == 32'd0, "R7 fail_addr zero", 64'(fail_addr), 64'd0);
        chk(ram[0] == ~exp_pat[0], "R1 first word is seed successor", ~ram[0], exp_pat[0]);
        bad = 0;
        for (int i = 0; i < NW; i++) if (ram[i] !== ~exp_pat[i]) bad++;
        chk(bad == 0, "R3 R4 all words inverted pattern", 64'(bad), 64'd0);
        chk(range_errs == 0, "R2 R8 address range and outstanding", 64'(range_errs), 64'd0);
        after_done();
    endtask

    task automatic t_fill_fault(input int k);
        int cyc;
        flt_en = 1'b1; flt_idx = k; flt_mask = 64'd1; flt_val = ~exp_pat[k] & 64'd1;
        clear_mem();
        run_once(1'b0, cyc);
        chk(fail && !pass, "R6 fill fault flagged", {62'd0, pass, fail}, 64'd1);
        chk(fail_addr == ALIGN + 32'(k * 8), "R6 fill fault address",
            64'(fail_addr), 64'(ALIGN + 32'(k * 8)));
        if (k + 1 < NW)
            chk(ram[k + 1] == exp_pat[k + 1], "R6 stop at once", ram[k + 1], exp_pat[k + 1]);
        if (k > 0)
            chk(ram[k - 1] == ~exp_pat[k - 1], "R4 inverted before fault", ram[k - 1], ~exp_pat[k - 1]);
        after_done();
        flt_en = 1'b0;
    endtask

    task automatic t_verify_fault(input int k);
        int cyc;
        int b;
        b = 0;
        for (int j = 63; j >= 0; j--) if (exp_pat[k][j]) b = j;
        flt_en = 1'b1; flt_idx = k; flt_mask = 64'd1 << b; flt_val = 64'd1 << b;
        clear_mem();
        run_once(1'b0, cyc);
        chk(fail && !pass, "R5 verify fault flagged", {62'd0, pass, fail}, 64'd1);
        chk(fail_addr == ALIGN + 32'(k * 8), "R5 verify fault address",
            64'(fail_addr), 64'(ALIGN + 32'(k * 8)));
        chk(ram[NW - 1] == ~exp_pat[NW - 1], "R4 check pass completed", ram[NW - 1], ~exp_pat[NW - 1]);
        repeat (10) @(negedge clk);
        chk(fail && fail_addr == ALIGN + 32'(k * 8), "R10 verdict held",
            64'(fail_addr), 64'(ALIGN + 32'(k * 8)));
        flt_en = 1'b0;
    endtask

    task automatic t_start_ignored(input int ref_cyc);
        int cyc;
        int d0;
        flt_en = 1'b0;
        clear_mem();
        d0 = done_cnt;
        run_once(1'b1, cyc);
        chk(cyc == ref_cyc, "R9 run length unchanged", 64'(cyc), 64'(ref_cyc));
        chk(pass, "R9 pass with pokes", {63'd0, pass}, 64'd1);
        after_done();
        chk(done_cnt - d0 == 1, "R9 single done", 64'(done_cnt - d0), 64'd1);
    endtask

    task automatic t_restart();
        int cyc;
        flt_en = 1'b1; flt_idx = 5; flt_mask = 64'd1; flt_val = ~exp_pat[5] & 64'd1;
        clear_mem();
        @(negedge clk); start = 1'b1; cyc = 0;
        @(negedge clk);
        while (!done && cyc < 40000) begin @(negedge clk); cyc++; end
        chk(fail, "R12 first verdict", {63'd0, fail}, 64'd1);
        @(negedge clk); start = 1'b0;
        chk(busy && !fail && !pass, "R12 restart clears verdict",
            {61'd0, busy, fail, pass}, 64'd4);
        cyc = 0;
        while (!done && cyc < 40000) begin @(negedge clk); cyc++; end
        chk(fail && fail_addr == ALIGN + 32'd40, "R12 second run verdict",
            64'(fail_addr), 64'(ALIGN + 32'd40));
        after_done();
        flt_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int ref_cyc;
        logic [63:0] s;
        s = SEEDV;
        for (int i = 0; i < NW; i++) begin
            s = {s[0] ^ s[1] ^ s[3] ^ s[4], s[63:1]};
            exp_pat[i] = s;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean(ref_cyc);
        t_fill_fault(700);
        t_fill_fault(0);
        t_fill_fault(NW - 1);
        t_verify_fault(333);
        t_start_ignored(ref_cyc);
        t_restart();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule